// File: doc/BRIEF.md
# Horizontal Blanking and Clock Parking Generator

This block drives the horizontal blanking window of an image sensor readout line and holds the four horizontal shift clocks at fixed levels while that window is open. A per-line pixel counter restarts on every horizontal sync. The counter is compared against up to six stored pixel positions. Each position the counter reaches flips the blanking state. A line therefore starts unblanked and can hold up to three separate blanking windows. While blanking is active, the four incoming clock phases are replaced by a parked pattern. A per-sequence park bit chooses between two patterns. Outside blanking, the phases pass through unchanged.

Four sequences are stored, each holding six positions and one park bit. They are loaded through a simple one-cycle write port. A select input picks which sequence governs a line. The selection and the contents of the chosen sequence are copied into a working set at the sync edge. Writes and select changes made during a line therefore take effect only from the next line.

Top module: `hblank_gen`

## Requirements
- R1: After reset and before the first sync, `blank` is 0 and `hClkOut` equals `hClkIn`.
- R2: The clock edge that samples `hSync` high starts a new line. The cycle after that edge is pixel 0, and each later clock advances the pixel index by one, up to pixel `LineLen-1`.
- R3: During pixel p, `blank` is 1 exactly when an odd number of distinct stored positions of the working sequence are less than or equal to p. Each line starts unblanked.
- R4: While `blank` is 1 and the working park bit is 1, `hClkOut` is 4'b1010 (bit 0 = phase 1 low, bit 1 = phase 2 high, bit 2 = phase 3 low, bit 3 = phase 4 high).
- R5: While `blank` is 1 and the working park bit is 0, `hClkOut` is 4'b0101, and it stays constant for the whole blanking window.
- R6: A stored position equal to another position of the same sequence adds no extra toggle. Equal positions give one toggle in total.
- R7: A stored position of `LineLen` or greater is never reached and has no effect on `blank`.
- R8: Register writes and `seqSel` changes made during a line do not alter that line. The values present at the sync edge govern the following line.
- R9: While `blank` is 0, `hClkOut` equals `hClkIn` in the same cycle.
- R10: After pixel `LineLen-1`, and until the next sync, `blank` and the park pattern keep the state they had at the last pixel.
- R11: Write port: `wrIdx` 0 to 5 writes position slot `wrIdx` of sequence `wrSeq` from `wrData`. `wrIdx` 6 writes the park bit from `wrData[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| hSync | input | 1 | Line start strobe, one cycle high |
| seqSel | input | SelW (2) | Sequence used for the next line |
| wrEn | input | 1 | Register write strobe |
| wrSeq | input | SelW (2) | Sequence addressed by a write |
| wrIdx | input | IdxW (3) | Slot addressed: 0-5 position, 6 park bit |
| wrData | input | PosW (12) | Write data |
| hClkIn | input | 4 | Free-running horizontal clock phases, bit 0 = phase 1 |
| blank | output | 1 | Blanking indicator |
| hClkOut | output | 4 | Gated horizontal clock phases |

## Verification
The bench targets several boundary cases:
- A toggle at pixel 0. A design that counts from 1, or that registers the comparison, would start blanking one pixel late.
- A toggle at the last pixel, followed by idle cycles after the line. A counter that wraps or keeps comparing would flip `blank` again.
- Repeated positions. A design that sums matches instead of OR-ing them would cancel a window.
- Positions beyond the line length, which must never be reached.
- Writes and a select change in mid-line. A design without a working copy would change the current line's windows.

Each pixel's `blank` and `hClkOut` are compared with a model built from the position list, under both park patterns.

// File: rtl/hblank_pkg.sv
package hblank_pkg;

  // Strobes from line control to the blanking datapath
  typedef struct packed {
    logic loadLine;  // sync edge: latch working sequence, clear state
    logic advance;   // a pixel of the current line is in progress
  } hbStrobes_t;

  localparam int NumPhases = 4;

  // Parked phase levels during blanking, bit 0 = phase 1
  function automatic logic [NumPhases-1:0] parkLevels(input logic parkBit);
    return parkBit ? 4'b1010 : 4'b0101;
  endfunction

endpackage

// File: rtl/hblank_ctrl.sv
module hblank_ctrl
  import hblank_pkg::*;
#(
  parameter int PosW    = 12,
  parameter int LineLen = 4096
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hSync,
  output hbStrobes_t      strobes,
  output logic [PosW-1:0] pixCnt,
  output logic            running
);

  localparam logic [PosW-1:0] LastPix = PosW'(LineLen - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt  <= '0;
      running <= 1'b0;
    end else if (hSync) begin
      pixCnt  <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (pixCnt == LastPix) begin
        running <= 1'b0;
      end else begin
        pixCnt <= pixCnt + PosW'(1);
      end
    end
  end

  always_comb begin
    strobes.loadLine = hSync;
    strobes.advance  = running;
  end

endmodule

// File: rtl/hblank_dp.sv
module hblank_dp
  import hblank_pkg::*;
#(
  parameter int NumSeq = 4,
  parameter int NumTog = 6,
  parameter int PosW   = 12,
  parameter int SelW   = 2,
  parameter int IdxW   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hbStrobes_t           strobes,
  input  logic [PosW-1:0]      pixCnt,
  input  logic [SelW-1:0]      seqSel,
  input  logic                 wrEn,
  input  logic [SelW-1:0]      wrSeq,
  input  logic [IdxW-1:0]      wrIdx,
  input  logic [PosW-1:0]      wrData,
  input  logic [NumPhases-1:0] hClkIn,
  output logic                 blank,
  output logic [NumPhases-1:0] hClkOut
);

  localparam logic [IdxW-1:0] ParkIdx = IdxW'(NumTog);

  logic [PosW-1:0] posBank [NumSeq][NumTog];
  logic [NumSeq-1:0] parkBank;
  logic [PosW-1:0] workPos [NumTog];
  logic workPark;
  logic [NumTog-1:0] match;
  logic hit;
  logic stateR;

  // Stored sequences
  for (genvar s = 0; s < NumSeq; s++) begin : g_seq
    for (genvar t = 0; t < NumTog; t++) begin : g_tog
      always_ff @(posedge clk) begin
        if (!rstN) begin
          posBank[s][t] <= '1;
        end else if (wrEn && wrSeq == SelW'(s) && wrIdx == IdxW'(t)) begin
          posBank[s][t] <= wrData;
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        parkBank[s] <= 1'b0;
      end else if (wrEn && wrSeq == SelW'(s) && wrIdx == ParkIdx) begin
        parkBank[s] <= wrData[0];
      end
    end
  end

  // Working copy, taken at the sync edge
  for (genvar t = 0; t < NumTog; t++) begin : g_work
    always_ff @(posedge clk) begin
      if (!rstN) begin
        workPos[t] <= '1;
      end else if (strobes.loadLine) begin
        workPos[t] <= posBank[seqSel][t];
      end
    end
    assign match[t] = (workPos[t] == pixCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workPark <= 1'b0;
    end else if (strobes.loadLine) begin
      workPark <= parkBank[seqSel];
    end
  end

  // Equal positions collapse into a single toggle through the OR
  assign hit = strobes.advance && (|match);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR <= 1'b0;
    end else if (strobes.loadLine) begin
      stateR <= 1'b0;
    end else if (hit) begin
      stateR <= ~stateR;
    end
  end

  assign blank   = stateR ^ hit;
  assign hClkOut = blank ? parkLevels(workPark) : hClkIn;

endmodule

// File: rtl/hblank_gen.sv
module hblank_gen
  import hblank_pkg::*;
#(
  parameter int LineLen = 4096,
  parameter int NumSeq  = 4,
  parameter int NumTog  = 6,
  parameter int PosW    = 12,
  parameter int SelW    = $clog2(NumSeq),
  parameter int IdxW    = $clog2(NumTog + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hSync,
  input  logic [SelW-1:0] seqSel,
  input  logic            wrEn,
  input  logic [SelW-1:0] wrSeq,
  input  logic [IdxW-1:0] wrIdx,
  input  logic [PosW-1:0] wrData,
  input  logic [3:0]      hClkIn,
  output logic            blank,
  output logic [3:0]      hClkOut
);

  hbStrobes_t      strobes;
  logic [PosW-1:0] pixCnt;
  logic            running;

  hblank_ctrl #(.PosW(PosW), .LineLen(LineLen)) u_ctrl (
    .clk(clk), .rstN(rstN), .hSync(hSync),
    .strobes(strobes), .pixCnt(pixCnt), .running(running)
  );

  hblank_dp #(
    .NumSeq(NumSeq), .NumTog(NumTog), .PosW(PosW), .SelW(SelW), .IdxW(IdxW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixCnt(pixCnt),
    .seqSel(seqSel), .wrEn(wrEn), .wrSeq(wrSeq), .wrIdx(wrIdx),
    .wrData(wrData), .hClkIn(hClkIn), .blank(blank), .hClkOut(hClkOut)
  );

endmodule

// File: rtl/hblank_gen_chk.sv
module hblank_gen_chk #(
  parameter int PosW = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            hSync,
  input logic            blank,
  input logic [3:0]      hClkIn,
  input logic [3:0]      hClkOut,
  input logic [PosW-1:0] pixCnt,
  input logic            running
);

  p_line_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    hSync |=> (pixCnt == '0 && running));

  p_passthru_r9: assert property (@(posedge clk) disable iff (!rstN)
    !blank |-> (hClkOut == hClkIn));

  p_park_levels_r4: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> (hClkOut == 4'b1010 || hClkOut == 4'b0101));

  p_park_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (blank && $past(blank) && !$past(hSync)) |-> $stable(hClkOut));

  p_hold_after_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !$past(running) && !$past(hSync)) |-> $stable(blank));

endmodule

bind hblank_gen hblank_gen_chk #(.PosW(PosW)) u_chk (
  .clk(clk), .rstN(rstN), .hSync(hSync), .blank(blank),
  .hClkIn(hClkIn), .hClkOut(hClkOut), .pixCnt(pixCnt), .running(running)
);

// File: tb/hblank_gen_bench.sv
`timescale 1ns/1ps
module hblank_gen_bench;
  localparam int L = 200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, hSync = 1'b0, wrEn = 1'b0;
  logic [1:0] seqSel = '0, wrSeq = '0;
  logic [2:0] wrIdx = '0;
  logic [11:0] wrData = '0;
  logic [3:0] hClkIn = '0;
  logic blank;
  logic [3:0] hClkOut;

  int nChk = 0, nFail = 0;
  bit done = 0;
  int bPos[4][6];
  bit bMask[4];
  int aPos[6];
  bit aMask;

  hblank_gen #(.LineLen(L)) u_hblank_gen (
    .clk(clk), .rstN(rstN), .hSync(hSync), .seqSel(seqSel), .wrEn(wrEn),
    .wrSeq(wrSeq), .wrIdx(wrIdx), .wrData(wrData), .hClkIn(hClkIn),
    .blank(blank), .hClkOut(hClkOut)
  );

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] park(bit m);
    return m ? 4'b1010 : 4'b0101;
  endfunction

  // Model of R3, R6, R7: parity of distinct reachable positions up to p
  function automatic bit expBlank(int p);
    int cnt = 0;
    for (int t = 0; t < 6; t++) begin
      bit dup = 0;
      for (int j = 0; j < t; j++) if (aPos[j] == aPos[t]) dup = 1;
      if (!dup && aPos[t] < L && aPos[t] <= p) cnt++;
    end
    return cnt[0];
  endfunction

  // R11 encoding: idx 0..5 positions, idx 6 park bit
  task automatic writeReg(int s, int idx, int val);
    @(negedge clk);
    wrEn = 1; wrSeq = 2'(s); wrIdx = 3'(idx); wrData = 12'(val);
    @(negedge clk);
    wrEn = 0;
    if (idx < 6) bPos[s][idx] = val; else bMask[s] = val[0];
  endtask

  task automatic loadSeq(int s, int p0, int p1, int p2, int p3, int p4, int p5, bit m);
    writeReg(s, 0, p0); writeReg(s, 1, p1); writeReg(s, 2, p2);
    writeReg(s, 3, p3); writeReg(s, 4, p4); writeReg(s, 5, p5);
    writeReg(s, 6, m);
  endtask

  task automatic runLine(string req, int wrAt, int wSeq, int wIdx, int wVal, int newSel);
    bit eb;
    @(negedge clk);
    hSync = 1;
    for (int t = 0; t < 6; t++) aPos[t] = bPos[seqSel][t];
    aMask = bMask[seqSel];
    @(negedge clk);
    hSync = 0;
    for (int p = 0; p < L; p++) begin
      hClkIn = 4'(p * 7 + 3);
      #1;
      eb = expBlank(p);
      check(req, $sformatf("blank pix %0d", p), {3'b0, blank}, {3'b0, eb});
      check(req, $sformatf("hclk pix %0d", p), hClkOut, eb ? park(aMask) : hClkIn);
      if (p == wrAt) begin
        wrEn = 1; wrSeq = 2'(wSeq); wrIdx = 3'(wIdx); wrData = 12'(wVal);
        if (wIdx < 6) bPos[wSeq][wIdx] = wVal; else bMask[wSeq] = wVal[0];
        if (newSel >= 0) seqSel = 2'(newSel);
      end else begin
        wrEn = 0;
      end
      @(negedge clk);
    end
    wrEn = 0;
    // R10: state held after the last pixel
    eb = expBlank(L - 1);
    for (int k = 0; k < 4; k++) begin
      hClkIn = 4'(k * 5 + 1);
      #1;
      check({req, " R10"}, "blank tail", {3'b0, blank}, {3'b0, eb});
      check({req, " R10"}, "hclk tail", hClkOut, eb ? park(aMask) : hClkIn);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rstN = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      hClkIn = 4'(k * 3 + 2);
      #1;
      check("R1 R9", "blank idle", {3'b0, blank}, 4'b0);
      check("R1 R9", "hclk idle", hClkOut, hClkIn);
    end
  endtask

  task automatic t_single_window();  // R2 R3 R4 R7
    loadSeq(0, 10, 20, 4095, 4095, 4095, 4095, 1);
    seqSel = 0;
    runLine("R2 R3 R4", -1, 0, 0, 0, -1);
  endtask

  task automatic t_three_windows();  // R3 R5, last pixel toggle R10
    loadSeq(1, 5, 15, 60, 90, 150, 199, 0);
    seqSel = 1;
    runLine("R3 R5", -1, 0, 0, 0, -1);
  endtask

  task automatic t_repeats();  // R6 R7
    loadSeq(2, 30, 40, 30, 60, 40, 250, 1);
    seqSel = 2;
    runLine("R6 R7", -1, 0, 0, 0, -1);
  endtask

  task automatic t_edges();  // toggles at pixel 0 and last pixel
    loadSeq(3, 0, 0, 0, 199, 300, 199, 0);
    seqSel = 3;
    runLine("R3 R6", -1, 0, 0, 0, -1);
  endtask

  task automatic t_deferred();  // R8
    seqSel = 0;
    runLine("R8 current", 50, 0, 1, 100, 3);
    runLine("R8 reselect", 20, 3, 6, 1, 0);
    runLine("R8 rewritten", -1, 0, 0, 0, -1);
    seqSel = 3;
    runLine("R8 park", -1, 0, 0, 0, -1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    t_reset();
    t_single_window();
    t_three_windows();
    t_repeats();
    t_edges();
    t_deferred();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule